// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces, one clock at a time, the column addresses for a synchronous DRAM burst. A mode write loads three settings from a 12-bit key: the burst length, the beat ordering (linear wrap or XOR interleave) and a CAS latency code. The block checks the key and refuses any reserved setting. When a read or write command starts a burst, the block takes a starting column. It then presents one column per enabled clock, together with a busy flag and a flag that marks the final beat.

A later command can cut a burst short in two ways. A new start abandons the running burst and begins again from its own column. A stop, which the controller raises when it precharges the row, ends the burst at once. In the full-page setting the burst never ends by itself: the column steps through all 512 positions and wraps until a start or a stop arrives. A clock-enable input freezes the whole block for each cycle it is low.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, busy, last_beat, col_out and mode_err are all 0, and lat_code is 3'b010. The reset settings are length code 010 (4 beats) with sequential order.
- R2: A mode write with cke high takes effect at the next edge. key[2:0] gives the length (000=1, 001=2, 010=4, 011=8, 111=full page), key[3] gives the order (0 sequential, 1 interleave), and key[6:4] is the latency code, which appears on lat_code. A start on the same edge still uses the previous settings.
- R3: A mode write is refused if key[11:7] is not zero, if the length code is 100, 101 or 110, if the latency code is outside 001..011, or if it asks for full page with interleave. A refused write sets mode_err and keeps every previous setting. An accepted write clears mode_err.
- R4: A start with cke high makes busy 1 and col_out equal to start_col at the next edge. last_beat is 1 at that edge only when the length is 1.
- R5: In sequential order with length BL, beat n has the low log2(BL) bits of start+n, wrapped inside the aligned block. The upper bits stay as they are in start.
- R6: In interleave order, beat n is start_col with its low log2(BL) bits XORed with n.
- R7: In full page, each beat is the previous column plus 1, modulo 512. last_beat never rises, and busy stays high until a start or a stop.
- R8: last_beat is high exactly on the final beat of a fixed-length burst. On the next enabled edge with no start, busy and last_beat fall and col_out holds its value.
- R9: A start while busy restarts from the new column with the current settings. A start and a stop on the same edge act as a start.
- R10: A stop with cke high and no start drops busy and last_beat at the next edge, and col_out holds. A stop while idle changes nothing.
- R11: While cke is low, start, stop and mode writes are ignored and every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the block |
| mode_wr | input | 1 | Mode write strobe |
| mode_key | input | 12 | Mode key: [2:0] length, [3] order, [6:4] latency, [11:7] must be zero |
| start | input | 1 | Burst start from a read or write command |
| start_col | input | 9 | First column of the burst |
| stop | input | 1 | Ends the running burst (precharge) |
| col_out | output | 9 | Column address of the current beat |
| busy | output | 1 | A burst is active |
| last_beat | output | 1 | Current beat is the last of a fixed-length burst |
| mode_err | output | 1 | Last mode write was refused |
| lat_code | output | 3 | Latency code now in force |

## Verification
Two pairs of functions can land on the same edge, and these are the cases that matter most. The first pair is a mode write with a start. The bench issues them together and expects the new burst to follow the old length and order, while lat_code changes. The second pair is a start with a stop, or a start during a running burst. Here the expected result is a clean restart from the new column with beat 0. A reference model in the bench reproduces each collision, both in directed form and under random stimulus. Every output is compared with the model on every cycle, and that includes cycles where cke is low in the middle of a collision.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   typedef struct packed {
      logic [2:0] len;
      logic       ilv;
      logic [2:0] lat;
   } mode_cfg_t;

   localparam logic [2:0] LEN_FULL = 3'b111;

   localparam mode_cfg_t CFG_RST = '{len: 3'b010, ilv: 1'b0, lat: 3'b010};

   function automatic logic len_legal(input logic [2:0] c);
      return (c <= 3'd3) || (c == LEN_FULL);
   endfunction

   function automatic logic lat_legal(input logic [2:0] c);
      return (c >= 3'd1) && (c <= 3'd3);
   endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
   import burst_col_pkg::*;
#(
   parameter int KEY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             wr,
   input  logic [KEY_W-1:0] key,
   output mode_cfg_t        cfg,
   output logic             err
);

   generate
      if (KEY_W < 8) begin : g_bad_key
         $error("burst_mode_reg: KEY_W must be at least 8");
      end
   endgenerate

   mode_cfg_t cand;
   logic      upper_clr;
   logic      ok;

   always_comb begin
      cand      = '{len: key[2:0], ilv: key[3], lat: key[6:4]};
      upper_clr = ~|key[KEY_W-1:7];
      ok        = upper_clr && len_legal(cand.len) && lat_legal(cand.lat)
                  && !((cand.len == LEN_FULL) && cand.ilv);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RST;
         err <= 1'b0;
      end else if (cke && wr) begin
         if (ok) begin
            cfg <= cand;
            err <= 1'b0;
         end else begin
            err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] mix;

   assign mix = ilv ? (base ^ beat) : (base + beat);

   // Bits under the mask follow the ordering rule; the rest keep the start column.
   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         assign col[i] = mask[i] ? mix[i] : base[i];
      end
   endgenerate

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
   import burst_col_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  mode_cfg_t        cfg,
   output logic [COL_W-1:0] col,
   output logic             busy,
   output logic             last
);

   generate
      if (COL_W < 3) begin : g_bad_col
         $error("burst_beat_seq: COL_W must cover an 8-beat block");
      end
   endgenerate

   logic [COL_W-1:0] base_q, beat_q, mask_q;
   logic             ilv_q, full_q;
   logic [COL_W-1:0] beat_nx, col_step, mask_d;
   logic             full_d;

   assign full_d  = (cfg.len == LEN_FULL);
   assign mask_d  = full_d ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << cfg.len[1:0]);
   assign beat_nx = beat_q + 1'b1;

   burst_col_map #(.COL_W(COL_W)) u_map (
      .base (base_q),
      .beat (beat_nx),
      .mask (mask_q),
      .ilv  (ilv_q),
      .col  (col_step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         mask_q <= '0;
         ilv_q  <= 1'b0;
         full_q <= 1'b0;
         col    <= '0;
         busy   <= 1'b0;
         last   <= 1'b0;
      end else if (cke) begin
         if (start) begin
            base_q <= start_col;
            beat_q <= '0;
            mask_q <= mask_d;
            ilv_q  <= cfg.ilv;
            full_q <= full_d;
            col    <= start_col;
            busy   <= 1'b1;
            last   <= !full_d && (mask_d == '0);
         end else if (stop) begin
            busy <= 1'b0;
            last <= 1'b0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               last <= 1'b0;
            end else begin
               beat_q <= beat_nx;
               col    <= col_step;
               last   <= !full_q && (beat_nx == mask_q);
            end
         end
      end
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W = 9,
   parameter int KEY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             mode_wr,
   input  logic [KEY_W-1:0] mode_key,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             busy,
   output logic             last_beat,
   output logic             mode_err,
   output logic [2:0]       lat_code
);

   mode_cfg_t cfg;

   burst_mode_reg #(.KEY_W(KEY_W)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .wr    (mode_wr),
      .key   (mode_key),
      .cfg   (cfg),
      .err   (mode_err)
   );

   burst_beat_seq #(.COL_W(COL_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .start     (start),
      .stop      (stop),
      .start_col (start_col),
      .cfg       (cfg),
      .col       (col_out),
      .busy      (busy),
      .last      (last_beat)
   );

   assign lat_code = cfg.lat;

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
   parameter int COL_W = 9,
   parameter int KEY_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             mode_wr,
   input logic [KEY_W-1:0] mode_key,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic             stop,
   input logic [COL_W-1:0] col_out,
   input logic             busy,
   input logic             last_beat,
   input logic             mode_err,
   input logic [2:0]       lat_code
);

   // R4
   start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && start) |=> (busy && col_out == $past(start_col)));

   // R8
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !start && last_beat) |=> (!busy && !last_beat && $stable(col_out)));

   // R8
   last_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> busy);

   // R10
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && stop && !start) |=> (!busy && !last_beat));

   // R11
   cke_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(col_out) && $stable(busy) && $stable(last_beat)
                && $stable(mode_err) && $stable(lat_code)));

   // R3
   upper_bits_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && mode_wr && (|mode_key[KEY_W-1:7])) |=> (mode_err && $stable(lat_code)));

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W), .KEY_W(KEY_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .mode_wr   (mode_wr),
   .mode_key  (mode_key),
   .start     (start),
   .start_col (start_col),
   .stop      (stop),
   .col_out   (col_out),
   .busy      (busy),
   .last_beat (last_beat),
   .mode_err  (mode_err),
   .lat_code  (lat_code)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RAND_STEPS = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        mode_wr = 1'b0;
   logic [11:0] mode_key = '0;
   logic        start = 1'b0;
   logic [8:0]  start_col = '0;
   logic        stop = 1'b0;
   logic [8:0]  col_out;
   logic        busy, last_beat, mode_err;
   logic [2:0]  lat_code;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_col_gen u_burst_col_gen (
      .clk (clk), .rst_n (rst_n), .cke (cke), .mode_wr (mode_wr),
      .mode_key (mode_key), .start (start), .start_col (start_col),
      .stop (stop), .col_out (col_out), .busy (busy),
      .last_beat (last_beat), .mode_err (mode_err), .lat_code (lat_code)
   );

   // reference model state
   logic [8:0] c_mask = 9'h003;
   logic       c_ilv = 1'b0, c_full = 1'b0;
   logic [2:0] c_lat = 3'b010;
   logic       m_err = 1'b0;
   logic       m_busy = 1'b0, m_last = 1'b0, m_ilv = 1'b0, m_full = 1'b0;
   logic [8:0] m_col = '0, m_base = '0, m_beat = '0, m_mask = '0;
   string      bt = "R1", mt = "R1";

   function automatic logic [8:0] len_mask(input logic [2:0] code);
      case (code)
         3'b000:  return 9'h000;
         3'b001:  return 9'h001;
         3'b010:  return 9'h003;
         3'b011:  return 9'h007;
         default: return 9'h1FF;
      endcase
   endfunction

   function automatic logic key_ok(input logic [11:0] k);
      logic len_ok, lat_ok;
      len_ok = (k[2:0] <= 3'd3) || (k[2:0] == 3'b111);
      lat_ok = (k[6:4] >= 3'd1) && (k[6:4] <= 3'd3);
      return (k[11:7] == 5'd0) && len_ok && lat_ok && !((k[2:0] == 3'b111) && k[3]);
   endfunction

   function automatic logic [8:0] col_of(input logic [8:0] b, n, m, input logic i);
      if (i) return b ^ (n & m);
      return (b & ~m) | ((b + n) & m);
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk(bt, "col_out", 32'(col_out), 32'(m_col));
      chk(bt, "busy", 32'(busy), 32'(m_busy));
      chk(bt, "last_beat", 32'(last_beat), 32'(m_last));
      chk(mt, "mode_err", 32'(mode_err), 32'(m_err));
      chk(mt, "lat_code", 32'(lat_code), 32'(c_lat));
   endtask

   task automatic model_step(input bit ck, st, input logic [8:0] c, input bit sp, wr,
                             input logic [11:0] k);
      if (!ck) begin
         bt = "R11"; mt = "R11";
         return;
      end
      mt = wr ? (key_ok(k) ? "R2" : "R3") : "R2";
      if (st) begin
         bt = (m_busy || sp) ? "R9" : "R4";
         m_busy = 1'b1; m_beat = '0; m_base = c; m_mask = c_mask;
         m_ilv = c_ilv; m_full = c_full; m_col = c;
         m_last = !c_full && (c_mask == 9'h000);
      end else if (sp) begin
         bt = "R10"; m_busy = 1'b0; m_last = 1'b0;
      end else if (m_busy) begin
         if (m_last) begin
            bt = "R8"; m_busy = 1'b0; m_last = 1'b0;
         end else begin
            bt = m_full ? "R7" : (m_ilv ? "R6" : "R5");
            m_beat = m_beat + 9'd1;
            m_col  = col_of(m_base, m_beat, m_mask, m_ilv);
            m_last = !m_full && (m_beat == m_mask);
         end
      end else begin
         bt = "R8";
      end
      if (wr) begin
         if (key_ok(k)) begin
            c_mask = len_mask(k[2:0]); c_ilv = k[3];
            c_full = (k[2:0] == 3'b111); c_lat = k[6:4]; m_err = 1'b0;
         end else begin
            m_err = 1'b1;
         end
      end
   endtask

   task automatic step(input bit ck, st, input logic [8:0] c, input bit sp, wr,
                       input logic [11:0] k);
      @(negedge clk);
      check_all();
      cke = ck; start = st; start_col = c; stop = sp; mode_wr = wr; mode_key = k;
      model_step(ck, st, c, sp, wr, k);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 9'h0, 0, 0, 12'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state checked by the first step
      idle(1);
      // R3 R6: interleave, length 8, latency 2
      step(1, 0, 0, 0, 1, 12'h02B);
      step(1, 1, 9'h0D5, 0, 0, 0); idle(9);
      // R5: sequential, length 8, wrap inside block
      step(1, 0, 0, 0, 1, 12'h023);
      step(1, 1, 9'h1FE, 0, 0, 0); idle(9);
      // R7: full page wrapping past 511, then stop (R10)
      step(1, 0, 0, 0, 1, 12'h037);
      step(1, 1, 9'h1FC, 0, 0, 0); idle(8);
      step(1, 0, 0, 1, 0, 0); idle(2);
      // R3: refused keys keep settings
      step(1, 0, 0, 0, 1, 12'h02F);
      step(1, 0, 0, 0, 1, 12'h0A3);
      step(1, 0, 0, 0, 1, 12'h003);
      step(1, 0, 0, 0, 1, 12'h024);
      step(1, 1, 9'h010, 0, 0, 0); idle(4);
      // R2: mode write with start on one edge, start keeps old setting
      step(1, 1, 9'h045, 0, 1, 12'h010); idle(4);
      step(1, 1, 9'h046, 0, 0, 0); idle(2);
      // R9: start during burst, start with stop
      step(1, 0, 0, 0, 1, 12'h01A);
      step(1, 1, 9'h101, 0, 0, 0); idle(1);
      step(1, 1, 9'h0F3, 0, 0, 0); idle(1);
      step(1, 1, 9'h033, 1, 0, 0); idle(5);
      // R11: cke low with commands present
      step(1, 1, 9'h020, 0, 0, 0);
      step(0, 1, 9'h1AA, 1, 1, 12'h013);
      step(0, 0, 0, 1, 0, 0); idle(5);
      // R10: stop while idle
      step(1, 0, 0, 1, 0, 0); idle(1);
      for (int i = 0; i < RAND_STEPS; i++) begin
         logic [11:0] k;
         logic [2:0]  lc;
         lc = ($urandom % 5 == 0) ? 3'($urandom) : 3'((($urandom % 4) == 3) ? 7 : ($urandom % 4));
         k = ($urandom % 4 == 0) ? 12'($urandom)
             : {5'd0, 3'(($urandom % 8 == 0) ? $urandom : (1 + $urandom % 3)),
                1'(($urandom % 3 == 0)), lc};
         step(($urandom % 8) != 0, ($urandom % 7) == 0, 9'($urandom),
              ($urandom % 19) == 0, ($urandom % 13) == 0, k);
      end
      @(negedge clk);
      check_all();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule